// File: doc/BRIEF.md
# Pattern-Based Fractional Clock Divider

The block derives a slower clock-enable stream from a fast input clock. It does this by circulating a programmed bit pattern around a shift register whose loop length can be chosen. Each fast cycle, the output is the bit currently at the head of the loop. Because the loop length need not be a multiple of the pattern's period, the block can produce non-integer average ratios such as 2.5, 3.5 and 3.75 as well as plain integer ones. One further loop setting selects a fixed internal 25-cycle sequence that yields an average ratio of 6.25. A bypass path gives divide-by-one, with the enable held high on every cycle.

The divider is programmed through a single 32-bit control word that is written in one cycle. The word carries the pattern, a loop-length select, a preset strobe, a bypass bit and an output enable. The intended sequence is as follows. Drop the enable. Set the select. Raise preset and write the pattern while preset is held. Lower preset, then raise the enable again. The output is modelled as a one-bit stream at the fast clock rate, so the downstream clock gate or enable logic sees one bit per input cycle.

Top module: `frac_pattern_div`

## Requirements
- R1: After reset the control word is cleared and `div_o` is 0.
- R2: Control word fields are pattern [14:0], preset bit 15, loop select [17:16], bypass bit 18 and enable bit 19. Bits 31:20 are ignored.
- R3: A write with the enable bit at 0 forces `div_o` to 0 from the next cycle onward, whatever the other fields hold.
- R4: A write with both bypass and enable at 1 makes `div_o` 1 on every following cycle, and the pattern and select have no effect.
- R5: While preset is 1, the shift register reloads from the pattern field every cycle and does not rotate, so `div_o` (when enabled) holds pattern bit 0.
- R6: After preset falls, `div_o` presents pattern bit 0 first, then bit 1, bit 2 and so on, one per cycle. Bit 0 re-enters at the top of the loop.
- R7: Select 0 gives a 12-cycle loop. For example, 0x0aaa gives 6 rising edges per loop (/2), and 0x0db6, 0x0ccc, 0x0e38 and 0x0fc0 give 4, 3, 2 and 1 rising edges.
- R8: Select 1 gives a 14-cycle loop. For example, 0x36cc, 0x3c78 and 0x3f80 give 4, 2 and 1 rising edges per loop (/3.5, /7, /14).
- R9: Select 2 gives a 15-cycle loop. For example, 0x5294, 0x6666, 0x739c, 0x78f0 and 0x7f80 give 6, 4, 3, 2 and 1 rising edges per loop (/2.5, /3.75, /5, /7.5, /15).
- R10: Select 3 ignores the pattern and plays an internal 25-cycle sequence. The output is high at positions 0-2, 6-8, 12-14 and 18-20 and low otherwise, which gives 4 rising edges per 25 cycles (/6.25). The sequence restarts at position 0 when preset falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 32 | Control word written when the strobe is high |
| div_o | output | 1 | Divided clock-enable stream, one bit per input cycle |

## Verification
The assertions check the following on every cycle:
- enable gating and bypass, relative to the write that set them;
- the per-cycle reload of the shift register from the pattern while preset is held;
- conservation of the number of set bits inside the active loop during rotation;
- the wrap point and range of the internal 25-cycle sequencer.

Only the bench scenarios can show that each table pattern yields the right number of rising edges and high cycles over a full loop. The same applies to rotation resuming from pattern bit 0 once preset falls, and to the exact shape of the 6.25 sequence.

// File: rtl/fpd_pkg.sv
package fpd_pkg;

    localparam int unsigned PAT_W      = 15;
    localparam int unsigned CTRL_W     = 32;
    localparam int unsigned PRESET_POS = 15;
    localparam int unsigned SEL_POS    = 16;
    localparam int unsigned BYPASS_POS = 18;
    localparam int unsigned ENABLE_POS = 19;

    localparam int unsigned LOOP_A = 12;
    localparam int unsigned LOOP_B = 14;
    localparam int unsigned LOOP_C = 15;

    localparam int unsigned SEQ_LEN    = 25;
    localparam int unsigned SEQ_PULSES = 4;
    localparam int unsigned SEQ_HIGH   = 3;
    localparam int unsigned SEQ_STEP   = 6;

    typedef enum logic [1:0] {
        LOOP_SHORT = 2'd0,
        LOOP_MID   = 2'd1,
        LOOP_LONG  = 2'd2,
        SEQ_FIXED  = 2'd3
    } loop_sel_e;

    typedef struct packed {
        logic [PAT_W-1:0] pattern;
        logic             preset;
        loop_sel_e        sel;
        logic             bypass;
        logic             enable;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(input logic [CTRL_W-1:0] w);
        ctrl_t c;
        c.pattern = w[PAT_W-1:0];
        c.preset  = w[PRESET_POS];
        c.sel     = loop_sel_e'(w[SEL_POS +: 2]);
        c.bypass  = w[BYPASS_POS];
        c.enable  = w[ENABLE_POS];
        return c;
    endfunction

endpackage

// File: rtl/fpd_ctrl_reg.sv
module fpd_ctrl_reg
    import fpd_pkg::*;
#(
    parameter int unsigned W = CTRL_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output ctrl_t        ctrl_o
);

    typedef struct packed {
        ctrl_t ctrl;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.ctrl = decode_ctrl(CTRL_W'(wdata_i));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o = st_q.ctrl;

endmodule

// File: rtl/fpd_rotator.sv
module fpd_rotator
    import fpd_pkg::*;
#(
    parameter int unsigned W  = PAT_W,
    parameter int unsigned LA = LOOP_A,
    parameter int unsigned LB = LOOP_B,
    parameter int unsigned LC = LOOP_C
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         preset_i,
    input  loop_sel_e    sel_i,
    input  logic [W-1:0] pattern_i,
    output logic [W-1:0] sr_o,
    output logic         bit_o
);

    localparam int unsigned LW = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0] sr;
    } rot_state_t;

    rot_state_t st_d, st_q;

    function automatic logic [LW-1:0] loop_len(input loop_sel_e s);
        case (s)
            LOOP_SHORT: return LW'(LA);
            LOOP_MID:   return LW'(LB);
            default:    return LW'(LC);
        endcase
    endfunction

    // Head bit moves to position len-1; bits at len and above are cleared.
    function automatic logic [W-1:0] rotate(input logic [W-1:0] v, input logic [LW-1:0] len);
        logic [W-1:0] keep;
        logic [W-1:0] shifted;
        keep    = (W'(1) << (len - LW'(1))) - W'(1);
        shifted = v >> 1;
        return (shifted & keep) | (W'(v[0]) << (len - LW'(1)));
    endfunction

    always_comb begin
        st_d = st_q;
        if (preset_i) begin
            st_d.sr = pattern_i;
        end else if (sel_i != SEQ_FIXED) begin
            st_d.sr = rotate(st_q.sr, loop_len(sel_i));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sr_o  = st_q.sr;
    assign bit_o = st_q.sr[0];

endmodule

// File: rtl/fpd_fixed_seq.sv
module fpd_fixed_seq
    import fpd_pkg::*;
#(
    parameter int unsigned LEN    = SEQ_LEN,
    parameter int unsigned PULSES = SEQ_PULSES,
    parameter int unsigned HIGH   = SEQ_HIGH,
    parameter int unsigned STEP   = SEQ_STEP
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    preset_i,
    input  logic                    active_i,
    output logic [$clog2(LEN)-1:0]  cnt_o,
    output logic                    bit_o
);

    localparam int unsigned CW       = $clog2(LEN);
    localparam int unsigned PW       = $clog2(STEP);
    localparam int unsigned HIGH_END = (PULSES - 1) * STEP + HIGH;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [PW-1:0] phase;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (preset_i || !active_i) begin
            st_d.cnt   = '0;
            st_d.phase = '0;
        end else if (st_q.cnt == CW'(LEN - 1)) begin
            st_d.cnt   = '0;
            st_d.phase = '0;
        end else begin
            st_d.cnt   = st_q.cnt + CW'(1);
            st_d.phase = (st_q.phase == PW'(STEP - 1)) ? '0 : st_q.phase + PW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign bit_o = (st_q.cnt < CW'(HIGH_END)) && (st_q.phase < PW'(HIGH));

endmodule

// File: rtl/frac_pattern_div.sv
module frac_pattern_div
    import fpd_pkg::*;
#(
    parameter int unsigned CFG_W = CTRL_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cfg_we_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    output logic             div_o
);

    localparam int unsigned SEQ_CW = $clog2(SEQ_LEN);

    ctrl_t              ctrl_q;
    logic [PAT_W-1:0]   rot_sr;
    logic               rot_bit;
    logic [SEQ_CW-1:0]  seq_cnt;
    logic               seq_bit;
    logic               seq_active;
    logic               div_d;

    fpd_ctrl_reg #(.W(CFG_W)) ctrl_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (cfg_we_i),
        .wdata_i (cfg_wdata_i),
        .ctrl_o  (ctrl_q)
    );

    fpd_rotator #(.W(PAT_W), .LA(LOOP_A), .LB(LOOP_B), .LC(LOOP_C)) rot_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .preset_i  (ctrl_q.preset),
        .sel_i     (ctrl_q.sel),
        .pattern_i (ctrl_q.pattern),
        .sr_o      (rot_sr),
        .bit_o     (rot_bit)
    );

    assign seq_active = (ctrl_q.sel == SEQ_FIXED);

    fpd_fixed_seq #(.LEN(SEQ_LEN), .PULSES(SEQ_PULSES), .HIGH(SEQ_HIGH), .STEP(SEQ_STEP)) seq_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .preset_i (ctrl_q.preset),
        .active_i (seq_active),
        .cnt_o    (seq_cnt),
        .bit_o    (seq_bit)
    );

    always_comb begin
        div_d = 1'b0;
        if (ctrl_q.enable) begin
            if (ctrl_q.bypass) begin
                div_d = 1'b1;
            end else if (seq_active) begin
                div_d = seq_bit;
            end else begin
                div_d = rot_bit;
            end
        end
    end

    assign div_o = div_d;

endmodule

// File: rtl/fpd_checker.sv
module fpd_checker
    import fpd_pkg::*;
(
    input logic                        clk_i,
    input logic                        rst_ni,
    input logic                        cfg_we_i,
    input logic [CTRL_W-1:0]           cfg_wdata_i,
    input logic                        div_o,
    input logic                        preset_i,
    input loop_sel_e                   sel_i,
    input logic [PAT_W-1:0]            pattern_i,
    input logic [PAT_W-1:0]            sr_i,
    input logic [$clog2(SEQ_LEN)-1:0]  seq_cnt_i
);

    localparam logic [PAT_W-1:0] MASK_A = PAT_W'((1 << LOOP_A) - 1);
    localparam logic [PAT_W-1:0] MASK_B = PAT_W'((1 << LOOP_B) - 1);
    localparam logic [PAT_W-1:0] MASK_C = PAT_W'((1 << LOOP_C) - 1);

    assert_gate_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && !cfg_wdata_i[ENABLE_POS]) |=> !div_o);

    assert_bypass_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && cfg_wdata_i[ENABLE_POS] && cfg_wdata_i[BYPASS_POS]) |=> div_o);

    assert_preset_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        preset_i |=> (sr_i == $past(pattern_i)));

    assert_rotate_keep_a_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!preset_i && sel_i == LOOP_SHORT)
        |=> ($countones(sr_i & MASK_A) == $past($countones(sr_i & MASK_A))));

    assert_rotate_keep_b_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!preset_i && sel_i == LOOP_MID)
        |=> ($countones(sr_i & MASK_B) == $past($countones(sr_i & MASK_B))));

    assert_rotate_keep_c_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!preset_i && sel_i == LOOP_LONG)
        |=> ($countones(sr_i & MASK_C) == $past($countones(sr_i & MASK_C))));

    assert_seq_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i == SEQ_FIXED && !preset_i && seq_cnt_i == $clog2(SEQ_LEN)'(SEQ_LEN - 1))
        |=> (seq_cnt_i == '0));

    assert_seq_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_cnt_i < $clog2(SEQ_LEN)'(SEQ_LEN));

endmodule

bind frac_pattern_div fpd_checker chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_wdata_i (cfg_wdata_i),
    .div_o       (div_o),
    .preset_i    (ctrl_q.preset),
    .sel_i       (ctrl_q.sel),
    .pattern_i   (ctrl_q.pattern),
    .sr_i        (rot_sr),
    .seq_cnt_i   (seq_cnt)
);

// File: tb/frac_pattern_div_tb.sv
module frac_pattern_div_tb_top;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned WATCHDOG   = 20000;
    localparam logic [31:0] GARBAGE    = 32'hFFF0_0000;
    localparam logic [31:0] F_PRESET   = 32'h0000_8000;
    localparam logic [31:0] F_BYPASS   = 32'h0004_0000;
    localparam logic [31:0] F_ENABLE   = 32'h0008_0000;

    typedef struct packed {
        logic [14:0] pat;
        logic [1:0]  sel;
        logic [4:0]  len;
        logic [3:0]  edges;
    } vec_t;

    localparam int unsigned NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        '{15'h0aaa, 2'd0, 5'd12, 4'd6},
        '{15'h0db6, 2'd0, 5'd12, 4'd4},
        '{15'h0ccc, 2'd0, 5'd12, 4'd3},
        '{15'h0e38, 2'd0, 5'd12, 4'd2},
        '{15'h0fc0, 2'd0, 5'd12, 4'd1},
        '{15'h36cc, 2'd1, 5'd14, 4'd4},
        '{15'h3c78, 2'd1, 5'd14, 4'd2},
        '{15'h3f80, 2'd1, 5'd14, 4'd1},
        '{15'h5294, 2'd2, 5'd15, 4'd6},
        '{15'h6666, 2'd2, 5'd15, 4'd4},
        '{15'h739c, 2'd2, 5'd15, 4'd3},
        '{15'h78f0, 2'd2, 5'd15, 4'd2},
        '{15'h7f80, 2'd2, 5'd15, 4'd1},
        '{15'h0000, 2'd3, 5'd25, 4'd4},
        '{15'h7fff, 2'd3, 5'd25, 4'd4}
    };

    logic        clk;
    logic        rst_n;
    logic        cfg_we;
    logic [31:0] cfg_wdata;
    logic        div;

    int checks;
    int fails;

    frac_pattern_div dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .cfg_we_i    (cfg_we),
        .cfg_wdata_i (cfg_wdata),
        .div_o       (div)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic wr(input logic [31:0] w);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we    = 1'b0;
        cfg_wdata = '0;
    endtask

    function automatic int expected_ones(input vec_t v);
        int n;
        n = 0;
        if (v.sel == 2'd3) return 12;
        for (int i = 0; i < int'(v.len); i++) n += int'(v.pat[i]);
        return n;
    endfunction

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] base;
        int edges;
        int ones;
        int hi;
        logic prev;

        checks    = 0;
        fails     = 0;
        cfg_we    = 1'b0;
        cfg_wdata = '0;
        rst_n     = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset output", int'(div), 0);

        // Table walk: R2 garbage upper bits, R7/R8/R9/R10 ratios
        for (int k = 0; k < int'(NVEC); k++) begin
            base = GARBAGE | (32'(VECS[k].sel) << 16);
            wr(GARBAGE);
            wr(base);
            wr(base | F_PRESET);
            wr(base | F_PRESET | 32'(VECS[k].pat));
            wr(base | 32'(VECS[k].pat));
            check("R3 gated while reprogramming", int'(div), 0);
            wr(base | 32'(VECS[k].pat) | F_ENABLE);
            prev  = div;
            edges = 0;
            ones  = 0;
            for (int c = 0; c < int'(VECS[k].len); c++) begin
                @(negedge clk);
                if (!prev && div) edges++;
                ones += int'(div);
                prev = div;
            end
            check($sformatf("R7/R8/R9/R10 R2 edges vec%0d", k), edges, int'(VECS[k].edges));
            check($sformatf("R7/R8/R9/R10 ones vec%0d", k), ones, expected_ones(VECS[k]));
        end

        // R6: rotation begins at bit 0 and wraps after 12 cycles
        wr(32'h0);
        wr(F_ENABLE | F_PRESET | 32'h0001);
        wr(F_ENABLE | 32'h0001);
        check("R6 first bit after preset", int'(div), 1);
        hi = 0;
        for (int c = 1; c < 12; c++) begin
            @(negedge clk);
            hi += int'(div);
        end
        check("R6 middle bits", hi, 0);
        @(negedge clk);
        check("R6 bit0 returns at cycle 12", int'(div), 1);

        // R5: preset held keeps bit 0 on the output
        wr(F_ENABLE | F_PRESET | 32'h0001);
        hi = 0;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            hi += int'(div);
        end
        check("R5 preset hold", hi, 6);

        // R10: exact sequence shape after preset release
        wr(F_ENABLE | F_PRESET | (32'd3 << 16));
        wr(F_ENABLE | (32'd3 << 16));
        for (int c = 0; c < 25; c++) begin
            hi = (c < 21 && (c % 6) < 3) ? 1 : 0;
            check($sformatf("R10 seq pos %0d", c), int'(div), hi);
            @(negedge clk);
        end

        // R4: bypass with enable
        wr(F_BYPASS | F_ENABLE | 32'h0000);
        hi = 0;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            hi += int'(div);
        end
        check("R4 bypass high every cycle", hi, 8);

        // R3: bypass without enable stays low
        wr(F_BYPASS | 32'h7fff);
        hi = 0;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            hi += int'(div);
        end
        check("R3 disabled output low", hi, 0);

        // R1: reset mid-run clears the output
        wr(F_BYPASS | F_ENABLE);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset clears control", int'(div), 0);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule